// File: doc/BRIEF.md
# Dual-Command Watchdog Timer with Halt and Time-Out Flags

This block is a watchdog timer that counts a free-running clock through a prescaler stage and then an expiry counter. If software does not clear it in time, it fires. While the system runs normally, expiry produces a one-cycle reset pulse. While the system is halted, expiry produces a one-cycle wake-up pulse instead.

Clearing needs two different commands, A and B, given one after the other in either order. A lone command, or the same command repeated, does nothing. A stray write therefore cannot keep a runaway program alive.

Two sticky status bits report why the system last restarted. The time-out flag is set by expiry. The power-down flag is set by a halt command. A halt command also restarts the count and drops any half-finished clear sequence. The total period is 2^(PRE_W+CNT_W) clock cycles.

Top module: `wdog_dual_clear`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rst_pulse`, `wake_pulse`, `to_flag` and `pdf_flag` are all 0.
- R2: With no command inputs, the first expiry happens exactly 2^(PRE_W+CNT_W) clock edges after the last edge on which the count restarted. A restart is the last reset edge, a clear pair or a halt. Expiries then repeat with that same period.
- R3: Expiry while not halted drives `rst_pulse` high for exactly one cycle and sets `to_flag`. Both are visible in the cycle after the expiry edge.
- R4: A clear pair restarts the prescaler and the expiry counter, and clears `to_flag` and `pdf_flag`. A clear pair is a `clr_a` strobe completed by a `clr_b` strobe, or a `clr_b` strobe completed by a `clr_a` strobe.
- R5: A repeated strobe of the same clear command has no effect on the count or the flags. The clear sequence still remembers that this command came last, so A, A, B completes a pair.
- R6: `clr_a` and `clr_b` high in the same cycle are ignored. They do not restart the count, and the pending command state is unchanged.
- R7: `halt_cmd` restarts the prescaler and the expiry counter, sets `pdf_flag`, clears `to_flag`, forgets any pending clear command, and enters the halted state.
- R8: Expiry while halted drives `wake_pulse` high for one cycle instead of `rst_pulse`. It also sets `to_flag`, keeps `pdf_flag`, and leaves the halted state, so the next expiry gives a reset pulse. The halted state ends only through expiry or reset.
- R9: In a single cycle, halt has priority over a clear pair, and a clear pair has priority over expiry. An expiry that coincides with either of them produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running count clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_a | input | 1 | Clear command A strobe, one cycle |
| clr_b | input | 1 | Clear command B strobe, one cycle |
| halt_cmd | input | 1 | Halt command strobe, one cycle |
| rst_pulse | output | 1 | One-cycle reset request on expiry while running |
| wake_pulse | output | 1 | One-cycle wake-up request on expiry while halted |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
The interesting collision is an expiry that falls on the same edge as a completing clear command, or as a halt strobe. The bench counts edges from a known restart so that it can place the completing `clr_b` strobe, or the `halt_cmd` strobe, exactly on the expiry edge. It then checks that no pulse appears and that the flags take the value of the winning command. It also confirms that the next expiry arrives one full period after that edge. A halt strobe given together with a completing clear strobe is also checked: the power-down flag must stay set, and the pending command must be gone.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Which clear command was seen last in the current clear sequence.
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_GOT_A = 2'd1,
    SEQ_GOT_B = 2'd2
  } seq_e;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (PRE_W == 0) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
      logic [PRE_W-1:0] pcnt;

      always_ff @(posedge clk) begin
        if (rst || restart) pcnt <= '0;
        else                pcnt <= pcnt + PRE_W'(1);
      end

      assign tick = (pcnt == PRE_MAX);

      // R2: a restart always begins a fresh prescaler period.
      a_r2_pre_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick || (PRE_W == 1));
    end
  endgenerate
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] ecnt;

  always_ff @(posedge clk) begin
    if (rst || restart) ecnt <= '0;
    else if (tick)      ecnt <= ecnt + CNT_W'(1);
  end

  assign expire = tick && (ecnt == CNT_MAX);

  // R2: the counter can only move on a prescaler tick.
  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(ecnt));
endmodule

// File: rtl/wdg_clear_seq.sv
module wdg_clear_seq
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic clr_a,
  input  logic clr_b,
  output logic pair_done
);
  seq_e st;
  logic one_cmd;

  assign one_cmd   = clr_a ^ clr_b;
  assign pair_done = !flush && one_cmd &&
                     ((clr_a && st == SEQ_GOT_B) || (clr_b && st == SEQ_GOT_A));

  always_ff @(posedge clk) begin
    if (rst || flush)  st <= SEQ_IDLE;
    else if (pair_done) st <= SEQ_IDLE;
    else if (one_cmd)   st <= clr_a ? SEQ_GOT_A : SEQ_GOT_B;
  end

  // R5: repeating command A keeps A as the pending command.
  a_r5_repeat_a: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_GOT_A && clr_a && !clr_b && !flush) |=> st == SEQ_GOT_A);
  // R5: repeating command B keeps B as the pending command.
  a_r5_repeat_b: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_GOT_B && clr_b && !clr_a && !flush) |=> st == SEQ_GOT_B);
  // R6: simultaneous commands leave the sequence untouched.
  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b && !flush) |=> $stable(st));
  // R7: halt forgets the pending command.
  a_r7_flush_idle: assert property (@(posedge clk) disable iff (rst)
    flush |=> st == SEQ_IDLE);
endmodule

// File: rtl/wdog_dual_clear.sv
module wdog_dual_clear #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_a,
  input  logic clr_b,
  input  logic halt_cmd,
  output logic rst_pulse,
  output logic wake_pulse,
  output logic to_flag,
  output logic pdf_flag
);
  logic tick, expire, pair_done, restart, timeout_evt, halted;

  assign restart     = halt_cmd || pair_done;
  assign timeout_evt = expire && !restart;

  wdg_clear_seq u_seq (
    .clk(clk), .rst(rst), .flush(halt_cmd),
    .clr_a(clr_a), .clr_b(clr_b), .pair_done(pair_done)
  );

  wdg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      to_flag    <= 1'b0;
      pdf_flag   <= 1'b0;
      rst_pulse  <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      rst_pulse  <= 1'b0;
      wake_pulse <= 1'b0;
      if (halt_cmd) begin
        halted   <= 1'b1;
        pdf_flag <= 1'b1;
        to_flag  <= 1'b0;
      end else if (pair_done) begin
        pdf_flag <= 1'b0;
        to_flag  <= 1'b0;
      end else if (timeout_evt) begin
        to_flag    <= 1'b1;
        rst_pulse  <= !halted;
        wake_pulse <= halted;
        halted     <= 1'b0;
      end
    end
  end

  // R7: a halt strobe leaves PDF set and TO clear.
  a_r7_halt_flags: assert property (@(posedge clk) disable iff (rst)
    halt_cmd |=> pdf_flag && !to_flag);
  // R4: a completed clear pair drops both flags.
  a_r4_pair_clears: assert property (@(posedge clk) disable iff (rst)
    (pair_done && !halt_cmd) |=> !to_flag && !pdf_flag);
  // R3: the reset request lasts a single cycle.
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);
  // R3: every pulse is accompanied by TO.
  a_r3_to_with_pulse: assert property (@(posedge clk) disable iff (rst)
    (rst_pulse || wake_pulse) |-> to_flag);
  // R8: an expiry while halted yields a wake pulse only.
  a_r8_wake_when_halted: assert property (@(posedge clk) disable iff (rst)
    (halted && timeout_evt && !rst_pulse) |=> wake_pulse && !rst_pulse);
  // R9: the two requests never coincide, and neither follows a pre-empted expiry.
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rst_pulse && wake_pulse));
  a_r9_preempt: assert property (@(posedge clk) disable iff (rst)
    (expire && restart) |=> !rst_pulse && !wake_pulse);
endmodule

// File: tb/wdog_dual_clear_tb.sv
module wdog_dual_clear_tb_top;
  localparam int PRE_W  = 2;
  localparam int CNT_W  = 3;
  localparam int PERIOD = 1 << (PRE_W + CNT_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_a = 1'b0, clr_b = 1'b0, halt_cmd = 1'b0;
  logic rst_pulse, wake_pulse, to_flag, pdf_flag;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_dual_clear #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .clr_a(clr_a), .clr_b(clr_b), .halt_cmd(halt_cmd),
    .rst_pulse(rst_pulse), .wake_pulse(wake_pulse),
    .to_flag(to_flag), .pdf_flag(pdf_flag)
  );

  // Expected bits in order: rst_pulse, wake_pulse, to_flag, pdf_flag.
  task automatic expect4(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {rst_pulse, wake_pulse, to_flag, pdf_flag};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // One-cycle strobe; returns at the negedge after the edge that used it.
  task automatic strobe(logic a, logic b, logic h);
    clr_a = a; clr_b = b; halt_cmd = h;
    step(1);
    clr_a = 1'b0; clr_b = 1'b0; halt_cmd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(3);
    expect4("R1 in reset", 4'b0000);
    rst = 1'b0;
    step(1);
    expect4("R1 after reset", 4'b0000);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
  endtask

  task automatic t_free_run();
    do_reset();
    step(PERIOD - 1);
    expect4("R2 no early expiry", 4'b0000);
    step(1);
    expect4("R3 reset pulse and TO", 4'b1010);
    step(1);
    expect4("R3 pulse one cycle", 4'b0010);
    step(PERIOD - 2);
    expect4("R2 second period early", 4'b0010);
    step(1);
    expect4("R2 second expiry", 4'b1010);
  endtask

  task automatic t_pair(bit a_first);
    do_reset();
    step(PERIOD);
    strobe(a_first, !a_first, 1'b0);
    expect4("R4 first half keeps TO", 4'b0010);
    strobe(!a_first, a_first, 1'b0);
    expect4(a_first ? "R4 pair A-B clears" : "R4 pair B-A clears", 4'b0000);
    step(PERIOD - 1);
    expect4("R4 restart no early expiry", 4'b0000);
    step(1);
    expect4("R4 restart expiry", 4'b1010);
  endtask

  task automatic t_repeat();
    do_reset();
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0);
    step(PERIOD - 3);
    expect4("R5 repeat no restart early", 4'b0000);
    step(1);
    expect4("R5 repeat kept schedule", 4'b1010);
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0);
    expect4("R5 repeated A leaves TO", 4'b0010);
    strobe(1'b0, 1'b1, 1'b0);
    expect4("R5 A-A-B completes pair", 4'b0000);
  endtask

  task automatic t_both();
    do_reset();
    strobe(1'b1, 1'b1, 1'b0);
    step(PERIOD - 2);
    expect4("R6 both ignored early", 4'b0000);
    step(1);
    expect4("R6 both ignored expiry", 4'b1010);
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b1, 1'b1, 1'b0);
    strobe(1'b0, 1'b1, 1'b0);
    expect4("R6 pending A survived", 4'b0000);
    step(PERIOD - 1);
    expect4("R6 restart from B early", 4'b0000);
    step(1);
    expect4("R6 restart from B", 4'b1010);
  endtask

  task automatic t_halt();
    do_reset();
    step(PERIOD);
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b0, 1'b1);
    expect4("R7 halt sets PDF clears TO", 4'b0001);
    strobe(1'b0, 1'b1, 1'b0);
    expect4("R7 pending A forgotten", 4'b0001);
    step(PERIOD - 2);
    expect4("R8 no early wake", 4'b0001);
    step(1);
    expect4("R8 wake pulse", 4'b0111);
    step(PERIOD - 1);
    expect4("R8 halt left early", 4'b0011);
    step(1);
    expect4("R8 later expiry resets", 4'b1011);
    strobe(1'b0, 1'b1, 1'b0);
    strobe(1'b1, 1'b0, 1'b0);
    expect4("R4 pair clears PDF", 4'b0000);
  endtask

  task automatic t_priority();
    do_reset();
    strobe(1'b1, 1'b0, 1'b0);
    step(PERIOD - 2);
    strobe(1'b0, 1'b1, 1'b0);
    expect4("R9 pair beats expiry", 4'b0000);
    step(PERIOD - 1);
    expect4("R9 pair restart early", 4'b0000);
    step(1);
    expect4("R9 pair restart expiry", 4'b1010);
    do_reset();
    step(PERIOD - 1);
    strobe(1'b0, 1'b0, 1'b1);
    expect4("R9 halt beats expiry", 4'b0001);
    step(PERIOD);
    expect4("R9 halt restart wake", 4'b0111);
    do_reset();
    strobe(1'b1, 1'b0, 1'b0);
    strobe(1'b0, 1'b1, 1'b1);
    expect4("R9 halt beats pair", 4'b0001);
    strobe(1'b0, 1'b1, 1'b0);
    expect4("R9 sequence flushed", 4'b0001);
  endtask

  initial begin
    t_free_run();
    t_pair(1'b1);
    t_pair(1'b0);
    t_repeat();
    t_both();
    t_halt();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule